// File: doc/BRIEF.md
# Multi-cycle fetch sequencer

This block is the control heart of a small non-pipelined core. It owns the program counter and a phase state machine that walks every instruction through fetch, decode, execute and write-back, one phase per clock. Each phase has its own enable strobe, so the datapath stages around it know when to act. During fetch the counter is put on the instruction memory address. The returned word is held in an instruction register. During decode the address moves one word further, so that a second instruction word can be captured as a constant when the decoder asks for it.

The next counter value is built up as the instruction moves through the phases. The base step is one word. It is two words when the decoder reports a two-word instruction. A skip reported during execute adds the length of the instruction being skipped. A branch reported during write-back replaces the result with the supplied target. The counter changes only at the end of write-back. If an interrupt request is present at that point, the sequencer stores the computed next address as the return address, loads a fixed vector and spends one cycle in an interrupt-entry phase before fetching again. An undefined phase code falls back to the reset phase.

Top module: `fetch_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the phase is RESET (`phase_en` = 6'b000001), `pc_o` is 0 and `imem_addr` is 0. The next cycle is FETCH. Asserting `rst` in any phase returns the block to this state at the next edge.
- R2: `phase_en` is one-hot with bit 0 RESET, bit 1 FETCH, bit 2 DECODE, bit 3 EXECUTE, bit 4 WRITEBACK and bit 5 INTERRUPT. FETCH, DECODE, EXECUTE and WRITEBACK each last one cycle and follow in that order. WRITEBACK without an interrupt request returns to FETCH.
- R3: In FETCH, `imem_addr` equals `pc_o`, and `instr` is captured into `ir` at the end of that cycle. `ir` holds its value through the other phases.
- R4: In DECODE, `imem_addr` equals `pc_o` + 1. If `two_word` is high in DECODE, `instr` is captured into `konst`. `two_word` is ignored in every other phase.
- R5: With no skip and no branch, the next PC is `pc_o` + 1 for a one-word instruction and `pc_o` + 2 when `two_word` was high in DECODE.
- R6: A `skip_hit` that is high in EXECUTE adds 1 word to the step, or 2 words when `skip_long` is also high. `skip_hit` is ignored in every other phase.
- R7: A `br_take` that is high in WRITEBACK makes the next PC equal to `br_target`. `br_take` is ignored in every other phase.
- R8: `pc_o` is constant from RESET through FETCH, DECODE and EXECUTE, and during INTERRUPT. It changes only at the end of WRITEBACK.
- R9: An `irq` that is high in WRITEBACK moves the phase to INTERRUPT. At that same edge `ret_pc` receives the computed next PC and `pc_o` becomes VEC (default 1). The phase after INTERRUPT is FETCH. `irq` is ignored in every other phase.
- R10: All PC arithmetic, including the decode address, wraps modulo 2^AW (4096 words by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 16 | Word read from instruction memory |
| two_word | input | 1 | Decoder: current instruction carries a second word |
| skip_hit | input | 1 | Skip condition holds |
| skip_long | input | 1 | Skipped instruction is two words long |
| br_take | input | 1 | Use the branch target as the next PC |
| br_target | input | 12 | Branch target word address |
| irq | input | 1 | Interrupt request |
| imem_addr | output | 12 | Instruction memory word address |
| pc_o | output | 12 | Program counter |
| ret_pc | output | 12 | Return address saved on interrupt entry |
| ir | output | 16 | Fetched first instruction word |
| konst | output | 16 | Captured second instruction word |
| phase_en | output | 6 | One-hot phase enables |

## Verification
The bench builds the block with its defaults: AW = 12, IW = 16 and VEC = 1. With these values the top of the 4096-word space can be reached by a branch in a few cycles. The wrap of both the decode address and a two-word step can then be checked directly, and the interrupt vector differs from the reset address. Each vector also drives the decoder, skip, branch and interrupt inputs high in the phases where they must be ignored, so sampling in the wrong phase shows up as a wrong PC or a wrong phase.

// File: rtl/fetch_seq.sv
module fetch_seq #(
  parameter int AW  = 12,
  parameter int IW  = 16,
  parameter int VEC = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] instr,
  input  logic          two_word,
  input  logic          skip_hit,
  input  logic          skip_long,
  input  logic          br_take,
  input  logic [AW-1:0] br_target,
  input  logic          irq,
  output logic [AW-1:0] imem_addr,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] ret_pc,
  output logic [IW-1:0] ir,
  output logic [IW-1:0] konst,
  output logic [5:0]    phase_en
);

  typedef enum logic [2:0] {
    S_RST = 3'd0, S_FET = 3'd1, S_DEC = 3'd2,
    S_EXE = 3'd3, S_WB  = 3'd4, S_INT = 3'd5
  } st_t;

  st_t           st;
  logic [AW-1:0] pc;
  logic [2:0]    step;
  logic [AW-1:0] seq_pc, nxt_pc;

  assign seq_pc    = pc + AW'(step);
  assign nxt_pc    = br_take ? br_target : seq_pc;
  assign imem_addr = (st == S_DEC) ? pc + AW'(1) : pc;
  assign pc_o      = pc;

  always_comb begin
    phase_en = 6'b0;
    case (st)
      S_RST:   phase_en[0] = 1'b1;
      S_FET:   phase_en[1] = 1'b1;
      S_DEC:   phase_en[2] = 1'b1;
      S_EXE:   phase_en[3] = 1'b1;
      S_WB:    phase_en[4] = 1'b1;
      S_INT:   phase_en[5] = 1'b1;
      default: phase_en = 6'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_RST;
      pc     <= '0;
      step   <= 3'd1;
      ret_pc <= '0;
      ir     <= '0;
      konst  <= '0;
    end else begin
      case (st)
        S_RST: st <= S_FET;
        S_FET: begin
          ir <= instr;
          st <= S_DEC;
        end
        S_DEC: begin
          if (two_word) konst <= instr;
          step <= two_word ? 3'd2 : 3'd1;
          st   <= S_EXE;
        end
        S_EXE: begin
          if (skip_hit) step <= step + (skip_long ? 3'd2 : 3'd1);
          st <= S_WB;
        end
        S_WB: begin
          if (irq) begin
            ret_pc <= nxt_pc;
            pc     <= AW'(VEC);
            st     <= S_INT;
          end else begin
            pc <= nxt_pc;
            st <= S_FET;
          end
        end
        S_INT: st <= S_FET;
        default: st <= S_RST;
      endcase
    end
  end

endmodule

module fetch_seq_chk #(
  parameter int AW  = 12,
  parameter int VEC = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          irq,
  input logic [AW-1:0] imem_addr,
  input logic [AW-1:0] pc_o,
  input logic [5:0]    phase_en
);

  a_r1_reset_phase: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (phase_en == 6'b000001 && pc_o == '0));

  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_en) == 1);

  a_r2_fet_dec: assert property (@(posedge clk) disable iff (rst)
    phase_en[1] |=> phase_en[2]);

  a_r2_dec_exe: assert property (@(posedge clk) disable iff (rst)
    phase_en[2] |=> phase_en[3]);

  a_r2_exe_wb: assert property (@(posedge clk) disable iff (rst)
    phase_en[3] |=> phase_en[4]);

  a_r3_fetch_addr: assert property (@(posedge clk) disable iff (rst)
    phase_en[1] |-> imem_addr == pc_o);

  a_r4_decode_addr: assert property (@(posedge clk) disable iff (rst)
    phase_en[2] |-> imem_addr == AW'(pc_o + AW'(1)));

  a_r8_pc_hold: assert property (@(posedge clk) disable iff (rst)
    (phase_en[0] || phase_en[1] || phase_en[2] || phase_en[3] || phase_en[5]) |=> $stable(pc_o));

  a_r9_irq_entry: assert property (@(posedge clk) disable iff (rst)
    (phase_en[4] && irq) |=> (phase_en[5] && pc_o == AW'(VEC)));

  a_r9_int_exit: assert property (@(posedge clk) disable iff (rst)
    phase_en[5] |=> phase_en[1]);

endmodule

bind fetch_seq fetch_seq_chk #(.AW(AW), .VEC(VEC)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .imem_addr(imem_addr),
  .pc_o(pc_o), .phase_en(phase_en)
);

// File: tb/fetch_seq_bench.sv
module fetch_seq_bench;
  localparam int AW = 12;
  localparam int IW = 16;
  localparam int VEC = 1;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IW-1:0] instr = '0;
  logic two_word = 0, skip_hit = 0, skip_long = 0, br_take = 0, irq = 0;
  logic [AW-1:0] br_target = '0;
  logic [AW-1:0] imem_addr, pc_o, ret_pc;
  logic [IW-1:0] ir, konst;
  logic [5:0] phase_en;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [AW-1:0] pc_m;

  always #2.5 clk = ~clk;

  fetch_seq #(.AW(AW), .IW(IW), .VEC(VEC)) u_fetch_seq (
    .clk(clk), .rst(rst), .instr(instr), .two_word(two_word),
    .skip_hit(skip_hit), .skip_long(skip_long), .br_take(br_take),
    .br_target(br_target), .irq(irq), .imem_addr(imem_addr), .pc_o(pc_o),
    .ret_pc(ret_pc), .ir(ir), .konst(konst), .phase_en(phase_en)
  );

  localparam logic [15:0] V_W1 [NV] = '{16'h0C01, 16'h9100, 16'hFE03, 16'hFC12, 16'hCFF5,
                                       16'h0000, 16'h9200, 16'h2C01, 16'hC0FF, 16'hFE07};
  localparam logic [15:0] V_W2 [NV] = '{16'h0000, 16'h0060, 16'h0000, 16'h0000, 16'h0000,
                                       16'h0000, 16'h0123, 16'h0000, 16'h0000, 16'h0000};
  localparam logic V_TW [NV] = '{0, 1, 0, 0, 0, 0, 1, 0, 0, 0};
  localparam logic V_SK [NV] = '{0, 0, 1, 1, 0, 0, 0, 0, 0, 1};
  localparam logic V_SL [NV] = '{0, 0, 0, 1, 0, 0, 0, 0, 0, 1};
  localparam logic V_BR [NV] = '{0, 0, 0, 0, 1, 0, 0, 0, 1, 0};
  localparam logic [11:0] V_TG [NV] = '{12'h000, 12'h000, 12'h000, 12'h000, 12'hFFE,
                                       12'h000, 12'h000, 12'h000, 12'h100, 12'h000};
  localparam logic V_IQ [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 0};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_instr(input logic [15:0] w1, input logic [15:0] w2, input logic tw,
                           input logic sk, input logic sl, input logic br,
                           input logic [11:0] tg, input logic iq, input logic nz);
    int sum;
    logic [AW-1:0] nxt;
    sum = int'(pc_m) + (tw ? 2 : 1) + (sk ? (sl ? 2 : 1) : 0);
    nxt = br ? tg : AW'(sum);
    // FETCH
    chk("R2 fetch phase", 32'(phase_en), 32'h02);
    chk("R3 fetch addr", 32'(imem_addr), 32'(pc_m));
    instr = w1; two_word = nz; skip_hit = nz; skip_long = nz;
    br_take = nz; br_target = 12'h555; irq = nz;
    @(negedge clk);
    // DECODE
    chk("R3 ir capture", 32'(ir), 32'(w1));
    chk("R2 decode phase", 32'(phase_en), 32'h04);
    chk((pc_m == '1) ? "R10 decode addr wrap" : "R4 decode addr", 32'(imem_addr), 32'(AW'(pc_m + 1)));
    chk("R8 pc hold decode", 32'(pc_o), 32'(pc_m));
    instr = w2; two_word = tw; skip_hit = nz; skip_long = nz; br_take = nz; irq = nz;
    @(negedge clk);
    // EXECUTE
    chk("R2 execute phase", 32'(phase_en), 32'h08);
    if (tw) chk("R4 konst capture", 32'(konst), 32'(w2));
    instr = 16'hFFFF; two_word = nz; skip_hit = sk; skip_long = sl; br_take = nz; irq = nz;
    @(negedge clk);
    // WRITEBACK
    chk("R2 writeback phase", 32'(phase_en), 32'h10);
    chk("R8 pc hold writeback", 32'(pc_o), 32'(pc_m));
    chk("R3 ir holds", 32'(ir), 32'(w1));
    if (tw) chk("R4 konst holds", 32'(konst), 32'(w2));
    two_word = nz; skip_hit = nz; skip_long = nz; br_take = br; br_target = tg; irq = iq;
    @(negedge clk);
    two_word = 0; skip_hit = 0; skip_long = 0; br_take = 0; irq = 0; br_target = '0;
    if (iq) begin
      chk("R9 interrupt phase", 32'(phase_en), 32'h20);
      chk("R9 return pc", 32'(ret_pc), 32'(nxt));
      chk("R9 vector pc", 32'(pc_o), VEC);
      pc_m = AW'(VEC);
      @(negedge clk);
    end else begin
      pc_m = nxt;
      chk(br ? "R7 branch pc" : (sum >= 4096) ? "R10 pc wrap" : sk ? "R6 skip pc" : "R5 next pc",
          32'(pc_o), 32'(pc_m));
    end
    chk("R2 back to fetch", 32'(phase_en), 32'h02);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset phase", 32'(phase_en), 32'h01);
    chk("R1 reset pc", 32'(pc_o), 0);
    rst = 0;
    chk("R1 phase after release", 32'(phase_en), 32'h01);
    chk("R1 addr after release", 32'(imem_addr), 0);
    @(negedge clk);
    chk("R1 then fetch", 32'(phase_en), 32'h02);
    pc_m = '0;

    for (int i = 0; i < NV; i++)
      run_instr(V_W1[i], V_W2[i], V_TW[i], V_SK[i], V_SL[i], V_BR[i], V_TG[i], V_IQ[i], 1'(i % 2));

    // irq, branch and skip asserted only outside their own phases
    run_instr(16'h0F0F, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h0, 1'b0, 1'b1);
    chk("R9 no stray interrupt", 32'(pc_o), 32'(pc_m));

    // reset in the middle of an instruction
    instr = 16'h1234;
    @(negedge clk);
    @(negedge clk);
    chk("R2 execute before reset", 32'(phase_en), 32'h08);
    rst = 1;
    @(negedge clk);
    chk("R1 mid-run reset phase", 32'(phase_en), 32'h01);
    chk("R1 mid-run reset pc", 32'(pc_o), 0);
    rst = 0;
    @(negedge clk);
    chk("R1 fetch after mid-run reset", 32'(phase_en), 32'h02);
    pc_m = '0;
    run_instr(16'h9300, 16'hBEEF, 1'b1, 1'b0, 1'b0, 1'b0, 12'h0, 1'b0, 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule